// File: doc/BRIEF.md
# SRAM Word Parity Guard with Fault Injection

This block sits between a simple request/response word port and an on-block SRAM array. Every stored word gets one extra bit that holds its parity. On a write the block computes that bit and stores it with the data. On a read it recomputes parity over the returned word and compares it with the stored bit. A mismatch is reported with the read response. When the block is configured for it, a mismatch also latches the address of the failing read and raises an interrupt.

A test facility lets software force a parity fault on purpose. Software picks one word address and sets the fault enable. Any write to that word then stores the inverted parity bit, so the next read of that word reports a fault. This exercises the error path from end to end without any real memory defect.

Only the first fault is recorded. The captured address stays put until the error register is read. The read returns the held value and empties the register in the same access, and the interrupt drops with it.

Top module: `sram_parity_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bus_rvalid`, `bus_perr` and `irq` are 0 and `err_rd_addr` is 0.
- R2: A read request (`bus_req`=1, `bus_we`=0) at a clock edge gives `bus_rvalid`=1 for exactly the following cycle. In that cycle `bus_rdata` holds the last data written to that word. Any other cycle has `bus_rvalid`=0.
- R3: Parity is even. The stored bit is the XOR of all 32 data bits. With `cfg_par_en`=1, reading back a word that was written with `cfg_par_en`=1 and no injection gives `bus_perr`=0.
- R4: Parity is generated and checked only when `cfg_par_en`=1. A write made with it at 0 stores a parity bit of 0. A read requested with it at 0 never gives `bus_perr`=1 and never captures an error.
- R5: When `cfg_dbg_en`=1 and address bits [19:2] of a write equal `cfg_dbg_addr`, the inverted parity bit is stored. Bits [1:0] take no part in the match. A later checked read of that word gives `bus_perr`=1 in its response cycle.
- R6: With `cfg_dbg_en`=0, a write to the debug word stores correct parity.
- R7: With `cfg_dbg_en`=1, a write whose bits [19:2] differ from `cfg_dbg_addr` stores correct parity. This also holds when the write lands in the same array entry as the debug word through index aliasing (array index = bits [7:2]).
- R8: A response cycle with `bus_perr`=1 while nothing is pending sets `irq` to 1 from the next cycle on. From that cycle `err_rd_addr` shows the failing read address with bits [1:0] forced to 0.
- R9: While an error is pending, further parity errors change neither `err_rd_addr` nor `irq`.
- R10: A cycle with `err_rd`=1 is the read of the error register: `err_rd_addr` shows the held value during that cycle. From the next cycle `err_rd_addr` is 0 and `irq` is 0, unless R11 applies.
- R11: If `err_rd`=1 and `bus_perr`=1 fall in the same cycle, the new error is captured: the old one is cleared, and the new address and `irq`=1 appear on the next cycle.
- R12: A word stored with injected parity still returns its written data on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_par_en | input | 1 | Enables parity generation and checking |
| cfg_dbg_en | input | 1 | Enables forced-parity fault injection |
| cfg_dbg_addr | input | ADDR_W-2 | Word address (bits [19:2]) selected for injection |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DATA_W | Read data |
| bus_perr | output | 1 | Parity mismatch on the current response |
| err_rd | input | 1 | Read strobe of the clear-on-read error register |
| err_rd_addr | output | ADDR_W | Captured first-error address, 0 when empty |
| irq | output | 1 | High while a captured error is pending |

## Verification
A read accepted at edge N produces its response (`bus_rvalid`, `bus_rdata`, `bus_perr`) in the cycle after edge N. The capture of that response's error, and so `irq` and `err_rd_addr`, follows one edge later, at N+1. An `err_rd` strobe takes effect on the edge that ends its cycle. The bench drives inputs and compares all outputs at the falling edge, against a behavioural model that advances once per rising edge. Every result is therefore checked in exactly the cycle where it is due, never a cycle early or late.

// File: rtl/spg_pkg.sv
package spg_pkg;
   // kind of access presented on the word port in one cycle
   typedef enum logic [1:0] {
      SPG_OP_IDLE  = 2'd0,
      SPG_OP_WRITE = 2'd1,
      SPG_OP_READ  = 2'd2
   } spg_op_e;

   function automatic spg_op_e spg_decode(input logic req, input logic we);
      if (!req)    return SPG_OP_IDLE;
      else if (we) return SPG_OP_WRITE;
      else         return SPG_OP_READ;
   endfunction
endpackage

// File: rtl/spg_parity.sv
module spg_parity #(
   parameter int DATA_W  = 32,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic [DATA_W-1:0] data,
   output logic              par
);
   logic red;

   assign red = ^data;

   generate
      if (ODD_PAR) begin : g_odd
         assign par = ~red;
      end else begin : g_even
         assign par = red;
      end
   endgenerate
endmodule

// File: rtl/spg_wr_path.sv
module spg_wr_path #(
   parameter int DATA_W  = 32,
   parameter int WADDR_W = 18,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic               par_en,
   input  logic               dbg_en,
   input  logic [WADDR_W-1:0] dbg_word,
   input  logic [WADDR_W-1:0] wr_word,
   input  logic [DATA_W-1:0]  wdata,
   output logic               store_par
);
   logic gen_par;
   logic inject;

   spg_parity #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_gen (
      .data (wdata),
      .par  (gen_par)
   );

   // full word address compare, independent of array depth
   assign inject = dbg_en && (wr_word == dbg_word);

   always_comb begin
      if (par_en) store_par = gen_par ^ inject;
      else        store_par = 1'b0;
   end
endmodule

// File: rtl/spg_array.sv
module spg_array #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wpar,
   output logic [DATA_W-1:0] rdata,
   output logic              rpar
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int ROW_W = DATA_W + 1;

   logic [ROW_W-1:0] mem [DEPTH];
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[idx] <= {wpar, wdata};
      if (rd_en) row_q    <= mem[idx];
   end

   assign rdata = row_q[DATA_W-1:0];
   assign rpar  = row_q[DATA_W];
endmodule

// File: rtl/spg_rd_check.sv
module spg_rd_check #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 20,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              par_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] arr_data,
   input  logic              arr_par,
   output logic              rvalid,
   output logic              perr,
   output logic [ADDR_W-1:0] rsp_addr
);
   logic              rvalid_q;
   logic              chk_q;
   logic [ADDR_W-1:0] addr_q;
   logic              calc_par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         chk_q    <= 1'b0;
         addr_q   <= '0;
      end else begin
         rvalid_q <= rd_req;
         if (rd_req) begin
            chk_q  <= par_en;
            addr_q <= {rd_addr[ADDR_W-1:2], 2'b00};
         end
      end
   end

   spg_parity #(.DATA_W(DATA_W), .ODD_PAR(ODD_PAR)) u_chk (
      .data (arr_data),
      .par  (calc_par)
   );

   assign rvalid   = rvalid_q;
   assign perr     = rvalid_q && chk_q && (calc_par != arr_par);
   assign rsp_addr = addr_q;
endmodule

// File: rtl/spg_err_capture.sv
module spg_err_capture #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [ADDR_W-1:0] hit_addr,
   input  logic              clr,
   output logic              pend,
   output logic [ADDR_W-1:0] held_addr
);
   logic              pend_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
      end else if (clr) begin
         // register is being emptied: a simultaneous error takes the slot
         pend_q <= hit;
         addr_q <= hit ? hit_addr : '0;
      end else if (hit && !pend_q) begin
         pend_q <= 1'b1;
         addr_q <= hit_addr;
      end
   end

   assign pend      = pend_q;
   assign held_addr = addr_q;
endmodule

// File: rtl/sram_parity_guard.sv
module sram_parity_guard #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 20,
   parameter int IDX_W   = 6,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_par_en,
   input  logic              cfg_dbg_en,
   input  logic [ADDR_W-3:0] cfg_dbg_addr,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              bus_rvalid,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_perr,
   input  logic              err_rd,
   output logic [ADDR_W-1:0] err_rd_addr,
   output logic              irq
);
   import spg_pkg::*;

   localparam int WADDR_W = ADDR_W - 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must lie in 1..12");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W must cover the array index plus the byte offset");
      end
   endgenerate

   spg_op_e            op;
   logic               do_wr;
   logic               do_rd;
   logic [WADDR_W-1:0] word;
   logic [IDX_W-1:0]   idx;
   logic               store_par;
   logic [DATA_W-1:0]  arr_data;
   logic               arr_par;
   logic [ADDR_W-1:0]  rsp_addr;
   logic               perr;
   logic               rvalid;

   assign op    = spg_decode(bus_req, bus_we);
   assign do_wr = (op == SPG_OP_WRITE);
   assign do_rd = (op == SPG_OP_READ);
   assign word  = bus_addr[ADDR_W-1:2];
   assign idx   = word[IDX_W-1:0];

   spg_wr_path #(.DATA_W(DATA_W), .WADDR_W(WADDR_W), .ODD_PAR(ODD_PAR)) u_wr (
      .par_en    (cfg_par_en),
      .dbg_en    (cfg_dbg_en),
      .dbg_word  (cfg_dbg_addr),
      .wr_word   (word),
      .wdata     (bus_wdata),
      .store_par (store_par)
   );

   spg_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
      .clk   (clk),
      .wr_en (do_wr),
      .rd_en (do_rd),
      .idx   (idx),
      .wdata (bus_wdata),
      .wpar  (store_par),
      .rdata (arr_data),
      .rpar  (arr_par)
   );

   spg_rd_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ODD_PAR(ODD_PAR)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (do_rd),
      .par_en   (cfg_par_en),
      .rd_addr  (bus_addr),
      .arr_data (arr_data),
      .arr_par  (arr_par),
      .rvalid   (rvalid),
      .perr     (perr),
      .rsp_addr (rsp_addr)
   );

   spg_err_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (perr),
      .hit_addr  (rsp_addr),
      .clr       (err_rd),
      .pend      (irq),
      .held_addr (err_rd_addr)
   );

   assign bus_rvalid = rvalid;
   assign bus_rdata  = arr_data;
   assign bus_perr   = perr;
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_par_en,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_rvalid,
   input logic              bus_perr,
   input logic              err_rd,
   input logic [ADDR_W-1:0] err_rd_addr,
   input logic              irq
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!bus_rvalid && !bus_perr && !irq && err_rd_addr == '0));

   assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);

   assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);

   assert_perr_only_on_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_perr |-> bus_rvalid);

   assert_unchecked_read_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && !cfg_par_en) |=> !bus_perr);

   assert_error_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_perr |=> irq);

   assert_pending_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !err_rd) |=> (irq && $stable(err_rd_addr)));

   assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !bus_perr) |=> (!irq && err_rd_addr == '0));

   assert_addr_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_rd_addr[1:0] == 2'b00);
endmodule

bind sram_parity_guard spg_checker #(.ADDR_W(ADDR_W)) u_spg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_par_en  (cfg_par_en),
   .bus_req     (bus_req),
   .bus_we      (bus_we),
   .bus_rvalid  (bus_rvalid),
   .bus_perr    (bus_perr),
   .err_rd      (err_rd),
   .err_rd_addr (err_rd_addr),
   .irq         (irq)
);

// File: tb/sram_parity_guard_bench.sv
module sram_parity_guard_bench;
   localparam int DW = 32;
   localparam int AW = 20;
   localparam int IW = 6;
   localparam int DEPTH = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_par_en = 1'b0;
   logic          cfg_dbg_en = 1'b0;
   logic [AW-3:0] cfg_dbg_addr = '0;
   logic          bus_req = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_rvalid;
   logic [DW-1:0] bus_rdata;
   logic          bus_perr;
   logic          err_rd = 1'b0;
   logic [AW-1:0] err_rd_addr;
   logic          irq;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sram_parity_guard u_sram_parity_guard (
      .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .cfg_dbg_en(cfg_dbg_en),
      .cfg_dbg_addr(cfg_dbg_addr), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
      .bus_rdata(bus_rdata), .bus_perr(bus_perr), .err_rd(err_rd),
      .err_rd_addr(err_rd_addr), .irq(irq)
   );

   // behavioural reference state
   logic [DW-1:0] m_data [DEPTH];
   bit            m_par  [DEPTH];
   bit            m_rvalid = 0;
   logic [DW-1:0] m_rdata = '0;
   bit            m_perr = 0;
   logic [AW-1:0] m_raddr = '0;
   bit            m_pend = 0;
   logic [AW-1:0] m_eaddr = '0;

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // compare at the falling edge, then advance the model across one rising edge
   task automatic step(input string tag);
      int  i;
      bit  hit;
      chk(tag, "rvalid", 64'(bus_rvalid), 64'(m_rvalid));
      chk(tag, "perr", 64'(bus_perr), 64'(m_perr));
      if (m_rvalid) chk(tag, "rdata", 64'(bus_rdata), 64'(m_rdata));
      chk(tag, "irq", 64'(irq), 64'(m_pend));
      chk(tag, "err_rd_addr", 64'(err_rd_addr), 64'(m_eaddr));
      hit = m_rvalid && m_perr;
      if (err_rd) begin
         m_pend  = hit;
         m_eaddr = hit ? m_raddr : '0;
      end else if (hit && !m_pend) begin
         m_pend  = 1;
         m_eaddr = m_raddr;
      end
      i = int'(bus_addr[IW+1:2]);
      m_rvalid = bus_req && !bus_we;
      if (bus_req && bus_we) begin
         m_data[i] = bus_wdata;
         m_par[i]  = cfg_par_en ? ((^bus_wdata) ^
                     (cfg_dbg_en && bus_addr[AW-1:2] == cfg_dbg_addr)) : 1'b0;
      end else if (bus_req) begin
         m_rdata = m_data[i];
         m_perr  = cfg_par_en && ((^m_data[i]) != m_par[i]);
         m_raddr = {bus_addr[AW-1:2], 2'b00};
      end
      if (!m_rvalid) m_perr = 0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      bus_req = 0; bus_we = 0; err_rd = 0;
      step(tag);
   endtask

   task automatic wr(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; err_rd = 0;
      step(tag);
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a);
      bus_req = 1; bus_we = 0; bus_addr = a; err_rd = 0;
      step(tag);
   endtask

   task automatic clear_err(input string tag);
      bus_req = 0; err_rd = 1;
      step(tag);
      err_rd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] pat;
      @(negedge clk);
      @(negedge clk);
      // R1: quiet outputs while reset is held
      chk("R1", "rvalid", 64'(bus_rvalid), 64'd0);
      chk("R1", "irq", 64'(irq), 64'd0);
      chk("R1", "err_rd_addr", 64'(err_rd_addr), 64'd0);
      rst_n = 1;
      idle("R1");

      // R3: normal even-parity traffic with checking on
      cfg_par_en = 1;
      wr("R3", 20'h00000, 32'h0000_0000);
      wr("R3", 20'h00004, 32'hFFFF_FFFF);
      wr("R3", 20'h00008, 32'h0000_0001);
      wr("R3", 20'h000FC, 32'hA5A5_5A5B);
      rd("R3", 20'h00000);
      rd("R2", 20'h00004);
      rd("R3", 20'h00008);
      idle("R2");
      rd("R3", 20'h000FC);
      idle("R3");

      // R5: injection on word 5; low address bits of the write are ignored
      cfg_dbg_en = 1; cfg_dbg_addr = 18'h00005;
      wr("R5", 20'h00017, 32'h1234_5678);
      wr("R7", 20'h00018, 32'h8765_4321);
      rd("R7", 20'h00018);
      rd("R5", 20'h00014);          // response carries the fault (R12 data intact)
      idle("R8");                   // irq and address appear now
      chk("R8", "err_rd_addr", 64'(err_rd_addr), 64'h14);
      chk("R8", "irq", 64'(irq), 64'd1);

      // R9: further errors leave the capture alone
      cfg_dbg_addr = 18'h00009;
      wr("R5", 20'h00024, 32'h0F0F_0F0F);
      rd("R9", 20'h00024);
      rd("R9", 20'h00014);
      idle("R9");
      chk("R9", "err_rd_addr", 64'(err_rd_addr), 64'h14);

      // R10: clear-on-read
      chk("R10", "held value", 64'(err_rd_addr), 64'h14);
      clear_err("R10");
      chk("R10", "irq", 64'(irq), 64'd0);
      chk("R10", "err_rd_addr", 64'(err_rd_addr), 64'd0);

      // R11: new error in the same cycle as the clearing read
      rd("R11", 20'h00014);
      idle("R11");                  // 0x14 captured
      rd("R11", 20'h00024);
      clear_err("R11");             // response of 0x24 coincides with err_rd
      idle("R11");
      chk("R11", "err_rd_addr", 64'(err_rd_addr), 64'h24);
      clear_err("R11");

      // R6: no injection while disabled
      cfg_dbg_en = 0;
      wr("R6", 20'h00024, 32'h0F0F_0F0F);
      rd("R6", 20'h00024);
      idle("R6");
      chk("R6", "irq", 64'(irq), 64'd0);

      // R7: aliased index, different full address, no injection
      cfg_dbg_en = 1;
      wr("R7", 20'h00124, 32'h3C3C_3C3D);
      rd("R7", 20'h00024);
      idle("R7");
      chk("R7", "irq", 64'(irq), 64'd0);

      // R4: injected word read with checking off, then on
      wr("R4", 20'h00024, 32'h7777_0001);
      cfg_par_en = 0;
      rd("R4", 20'h00024);
      idle("R4");
      chk("R4", "irq", 64'(irq), 64'd0);
      cfg_par_en = 1;
      rd("R4", 20'h00024);
      idle("R4");
      clear_err("R4");
      // R4: word written unchecked stores parity 0; odd-weight data then fails
      cfg_dbg_en = 0; cfg_par_en = 0;
      wr("R4", 20'h00030, 32'h0000_0007);
      wr("R4", 20'h00034, 32'h0000_0003);
      cfg_par_en = 1;
      rd("R4", 20'h00034);
      rd("R4", 20'h00030);
      idle("R4");
      clear_err("R4");

      // R2 R3 R5: mixed sweep
      cfg_dbg_en = 1; cfg_dbg_addr = 18'h0000C;
      pat = 32'hACE1_2468;
      for (int k = 0; k < 48; k++) begin
         pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
         wr("R2", AW'(k * 4), pat);
      end
      for (int k = 0; k < 48; k++) begin
         rd("R2", AW'(k * 4));
         if (k % 16 == 15) clear_err("R10");
      end
      idle("R12");
      clear_err("R10");
      idle("R10");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule